// File: doc/BRIEF.md
# Interrupt Request and Enable Unit

This block gathers the interrupt requests of a small microcontroller core and presents one request to the CPU sequencer. There are six sources: two active-low external pins, two timer overflow events, a serial port with separate receive and transmit events, and a third timer with an overflow event and an external-capture event. Each event lands in its own request flag. The flags are combined into six source requests. Each source request is gated by its own enable bit and by a global enable. The highest-ranked surviving request is then presented with its source index.

Each external pin can act as a level source or an edge source. In level mode the flag mirrors the synchronised pin. In edge mode a sampled high-to-low change sets the flag. When the sequencer acknowledges a vectored source, the unit clears only the flags that hardware owns: timer 0 and timer 1, and the external flags in edge mode. Serial and third-timer flags stay set until software clears them. Software can write the whole flag register to raise or cancel requests.

Top module: `irq_unit`

## Requirements
- R1: After reset, `enableOut`, `modeOut` and `flagsOut` are all zero and `irqReq` is 0.
- R2: Register writes use `regSel` 0 for the enable register, 1 for the mode register and 2 for the flag register; `regSel` 3 is ignored. Enable bits are: bit 0 ext0, bit 1 timer0, bit 2 ext1, bit 3 timer1, bit 4 serial, bit 5 timer2, bit 7 global. Bit 6 reads 0 and ignores writes. Mode bit 0 (ext0) and mode bit 1 (ext1) select edge mode when 1; the other written bits are dropped.
- R3: While enable bit 7 is 0, `irqReq` is 0 and `ackValid` clears no flag.
- R4: Source indices are ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5. `irqReq` is 1 when any source is both pending and enabled. `irqIdx` then gives the lowest such index.
- R5: In edge mode, a high-to-low change on an external pin sets that pin's flag at the third rising clock edge after the change. A low-to-high change sets nothing.
- R6: In level mode, the external flag is the inverse of the pin, with the same three-edge latency. An acknowledge does not clear it, and a software write to it has no lasting effect.
- R7: A one-cycle pulse on `tmrOvfSet[k]` sets the timer k flag. An acknowledge of that timer's index clears the flag.
- R8: In edge mode, an acknowledge of an external source's index clears that external flag in the next cycle.
- R9: The serial request is the OR of flags 4 (receive) and 5 (transmit). The timer2 request is the OR of flags 6 (overflow) and 7 (external). An acknowledge clears none of these four flags.
- R10: The flag register layout is: bit 0 ext0, bit 1 timer0, bit 2 ext1, bit 3 timer1, bit 4 receive, bit 5 transmit, bit 6 timer2 overflow, bit 7 timer2 external. A write replaces the edge-mode and event flags. A hardware set event in the same cycle wins over a write or an acknowledge clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinN | input | 2 | Raw active-low external request pins |
| tmrOvfSet | input | 2 | Timer 0/1 overflow event pulses |
| serRxSet | input | 1 | Serial receive-done pulse |
| serTxSet | input | 1 | Serial transmit-done pulse |
| t2OvfSet | input | 1 | Timer 2 overflow pulse |
| t2ExtSet | input | 1 | Timer 2 external event pulse |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWrData | input | 8 | Register write data |
| ackValid | input | 1 | Vector acknowledge strobe |
| ackIdx | input | 3 | Index of the vectored source |
| irqReq | output | 1 | Pending-and-enabled request present |
| irqIdx | output | 3 | Index of the highest-ranked request |
| enableOut | output | 8 | Enable register contents |
| modeOut | output | 2 | External trigger mode bits |
| flagsOut | output | 8 | Request flag register |

## Verification
The assertions assume that the event inputs are single-cycle pulses. They also assume that a register write and an acknowledge never arrive in the same cycle as a same-index set event they are meant to observe. The stimulus drives every pulse and strobe for exactly one clock. Pins change only between edges. Each check waits long enough for the synchroniser to settle before the next stimulus.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_FLAG = 8;
  localparam int NUM_EXT  = 2;
  localparam int IDX_W    = 3;
  localparam int REG_W    = 8;
  localparam int GLOBAL_BIT = 7;
  localparam logic [REG_W-1:0] ENABLE_MASK = 8'hBF;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_FLAGS  = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                wrFlags;
    logic [REG_W-1:0]    wrData;
    logic [NUM_FLAG-1:0] hwClr;
    logic [NUM_EXT-1:0]  edgeMode;
  } flagStrobe_t;
endpackage

// File: rtl/irq_flag_dpath.sv
module irq_flag_dpath
  import irq_unit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXT-1:0]  extPinN,
  input  logic [1:0]          tmrOvfSet,
  input  logic                serRxSet,
  input  logic                serTxSet,
  input  logic                t2OvfSet,
  input  logic                t2ExtSet,
  input  flagStrobe_t         strobe,
  output logic [NUM_FLAG-1:0] flagsOut
);
  logic [NUM_EXT-1:0]  synced;
  logic [NUM_EXT-1:0]  fallSeen;
  logic [NUM_FLAG-1:0] setEv;
  logic [NUM_FLAG-1:0] flagQ;
  logic [NUM_FLAG-1:0] flagNxt;

  for (genvar k = 0; k < NUM_EXT; k++) begin : gExt
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevLvl;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain   <= '1;
        prevLvl <= 1'b1;
      end else begin
        chain   <= {chain[SYNC_STAGES-2:0], extPinN[k]};
        prevLvl <= chain[SYNC_STAGES-1];
      end
    end
    assign synced[k]   = chain[SYNC_STAGES-1];
    assign fallSeen[k] = prevLvl & ~chain[SYNC_STAGES-1];

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.edgeMode[k] && $fell(synced[k])) |=> flagsOut[2*k]); // R5
  end

  always_comb begin
    setEv    = '0;
    setEv[0] = fallSeen[0] & strobe.edgeMode[0];
    setEv[1] = tmrOvfSet[0];
    setEv[2] = fallSeen[1] & strobe.edgeMode[1];
    setEv[3] = tmrOvfSet[1];
    setEv[4] = serRxSet;
    setEv[5] = serTxSet;
    setEv[6] = t2OvfSet;
    setEv[7] = t2ExtSet;
  end

  always_comb begin
    flagNxt = flagQ;
    if (strobe.wrFlags) flagNxt = strobe.wrData;
    flagNxt = flagNxt & ~strobe.hwClr;
    flagNxt = flagNxt | setEv;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (!strobe.edgeMode[k]) flagNxt[2*k] = ~synced[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNxt;
  end

  assign flagsOut = flagQ;

  AST_TMR0_SET: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvfSet[0] |=> flagsOut[1]); // R7
  AST_TMR1_SET: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvfSet[1] |=> flagsOut[3]); // R7
  AST_TMR0_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hwClr[1] && !tmrOvfSet[0]) |=> !flagsOut[1]); // R7
  AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagsOut[4] && !strobe.wrFlags) |=> flagsOut[4]); // R9
  AST_T2_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagsOut[6] && !strobe.wrFlags) |=> flagsOut[6]); // R9
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_unit_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regSel,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                ackValid,
  input  logic [IDX_W-1:0]    ackIdx,
  input  logic [NUM_FLAG-1:0] flagsIn,
  output flagStrobe_t         strobe,
  output logic [REG_W-1:0]    enableOut,
  output logic [NUM_EXT-1:0]  modeOut,
  output logic                irqReq,
  output logic [IDX_W-1:0]    irqIdx
);
  logic [REG_W-1:0]   enableReg;
  logic [NUM_EXT-1:0] modeReg;
  logic [NUM_SRC-1:0] srcReq;
  logic [NUM_SRC-1:0] gatedReq;
  logic [3:0]         hwOwned;
  regSel_e            selDec;

  assign selDec = regSel_e'(regSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= '0;
      modeReg   <= '0;
    end else if (regWrEn) begin
      if (selDec == SEL_ENABLE) enableReg <= regWrData & ENABLE_MASK;
      if (selDec == SEL_MODE)   modeReg   <= regWrData[NUM_EXT-1:0];
    end
  end

  always_comb begin
    srcReq[0] = flagsIn[0];
    srcReq[1] = flagsIn[1];
    srcReq[2] = flagsIn[2];
    srcReq[3] = flagsIn[3];
    srcReq[4] = flagsIn[4] | flagsIn[5];
    srcReq[5] = flagsIn[6] | flagsIn[7];
    gatedReq  = srcReq & enableReg[NUM_SRC-1:0] & {NUM_SRC{enableReg[GLOBAL_BIT]}};
  end

  always_comb begin
    irqIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (gatedReq[i]) irqIdx = IDX_W'(i);
    end
  end
  assign irqReq = |gatedReq;

  assign hwOwned = {1'b1, modeReg[1], 1'b1, modeReg[0]};

  always_comb begin
    strobe.hwClr = '0;
    if (ackValid && enableReg[GLOBAL_BIT] && ackIdx < IDX_W'(4)) begin
      strobe.hwClr[ackIdx] = hwOwned[ackIdx[1:0]];
    end
    strobe.wrFlags  = regWrEn && (selDec == SEL_FLAGS);
    strobe.wrData   = regWrData;
    strobe.edgeMode = modeReg;
  end

  assign enableOut = enableReg;
  assign modeOut   = modeReg;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !enableOut[GLOBAL_BIT] |-> !irqReq); // R3
  AST_NO_CLR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !enableOut[GLOBAL_BIT] |-> (strobe.hwClr == '0)); // R3
  AST_IDX_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> enableOut[irqIdx]); // R4
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.hwClr)); // R8
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] extPinN,
  input  logic [1:0] tmrOvfSet,
  input  logic       serRxSet,
  input  logic       serTxSet,
  input  logic       t2OvfSet,
  input  logic       t2ExtSet,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [7:0] regWrData,
  input  logic       ackValid,
  input  logic [2:0] ackIdx,
  output logic       irqReq,
  output logic [2:0] irqIdx,
  output logic [7:0] enableOut,
  output logic [1:0] modeOut,
  output logic [7:0] flagsOut
);
  flagStrobe_t strobe;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ackValid(ackValid), .ackIdx(ackIdx),
    .flagsIn(flagsOut), .strobe(strobe), .enableOut(enableOut),
    .modeOut(modeOut), .irqReq(irqReq), .irqIdx(irqIdx)
  );

  irq_flag_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .tmrOvfSet(tmrOvfSet),
    .serRxSet(serRxSet), .serTxSet(serTxSet), .t2OvfSet(t2OvfSet),
    .t2ExtSet(t2ExtSet), .strobe(strobe), .flagsOut(flagsOut)
  );
endmodule

// File: tb/sim_irq_unit.sv
`timescale 1ns/1ps
module sim_irq_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] extPinN = 2'b11;
  logic [1:0] tmrOvfSet = '0;
  logic serRxSet = 0, serTxSet = 0, t2OvfSet = 0, t2ExtSet = 0;
  logic regWrEn = 0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic ackValid = 0;
  logic [2:0] ackIdx = '0;
  logic irqReq;
  logic [2:0] irqIdx;
  logic [7:0] enableOut, flagsOut;
  logic [1:0] modeOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_unit u0 (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .tmrOvfSet(tmrOvfSet),
    .serRxSet(serRxSet), .serTxSet(serTxSet), .t2OvfSet(t2OvfSet),
    .t2ExtSet(t2ExtSet), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ackValid(ackValid), .ackIdx(ackIdx),
    .irqReq(irqReq), .irqIdx(irqIdx), .enableOut(enableOut),
    .modeOut(modeOut), .flagsOut(flagsOut)
  );

  // {enable, flags, expected request, expected index}
  localparam logic [19:0] VEC [0:9] = '{
    {8'h00, 8'hFF, 1'b0, 3'd0},
    {8'h7F, 8'hFF, 1'b0, 3'd0},
    {8'h80, 8'hFF, 1'b0, 3'd0},
    {8'hBF, 8'hFF, 1'b1, 3'd0},
    {8'hBE, 8'hFF, 1'b1, 3'd1},
    {8'h84, 8'h0F, 1'b1, 3'd2},
    {8'hB0, 8'h20, 1'b1, 3'd4},
    {8'hB0, 8'h80, 1'b1, 3'd5},
    {8'h88, 8'h05, 1'b0, 3'd0},
    {8'hFF, 8'h40, 1'b1, 3'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] data);
    regWrEn = 1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic ack(input logic [2:0] idx);
    ackValid = 1; ackIdx = idx;
    @(negedge clk);
    ackValid = 0;
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    chk("R1 enable", enableOut, 8'h00);
    chk("R1 mode", modeOut, 2'b00);
    chk("R1 flags", flagsOut, 8'h00);
    chk("R1 irqReq", irqReq, 1'b0);

    wrReg(2'd1, 8'hFF);
    chk("R2 mode bits", modeOut, 2'b11);
    wrReg(2'd3, 8'hFF);
    chk("R2 select 3 ignored", {enableOut, flagsOut}, 16'h0000);

    for (int i = 0; i < 10; i++) begin
      wrReg(2'd0, VEC[i][19:12]);
      wrReg(2'd2, VEC[i][11:4]);
      chk("R2 enable readback", enableOut, VEC[i][19:12] & 8'hBF);
      chk("R10 flag write", flagsOut, VEC[i][11:4]);
      chk("R4 irqReq", irqReq, VEC[i][3]);
      if (VEC[i][3]) chk("R4 irqIdx", irqIdx, VEC[i][2:0]);
    end

    wrReg(2'd0, 8'h00);
    wrReg(2'd2, 8'h00);

    // edge mode set timing
    extPinN[0] = 0;
    cyc(1); chk("R5 edge after 1", flagsOut[0], 1'b0);
    cyc(1); chk("R5 edge after 2", flagsOut[0], 1'b0);
    cyc(1); chk("R5 edge after 3", flagsOut[0], 1'b1);
    wrReg(2'd2, 8'h00);
    extPinN[0] = 1;
    cyc(4); chk("R5 rise sets nothing", flagsOut[0], 1'b0);

    // edge flag cleared by ack
    wrReg(2'd2, 8'h01);
    wrReg(2'd0, 8'h81);
    chk("R8 request", {irqReq, irqIdx}, {1'b1, 3'd0});
    ack(3'd0);
    chk("R8 ack clears edge flag", flagsOut[0], 1'b0);
    chk("R8 request gone", irqReq, 1'b0);

    // global off: no request, ack ignored
    wrReg(2'd2, 8'h01);
    wrReg(2'd0, 8'h01);
    chk("R3 gated request", irqReq, 1'b0);
    ack(3'd0);
    chk("R3 ack ignored", flagsOut[0], 1'b1);

    // timer flag set and clear
    wrReg(2'd2, 8'h00);
    tmrOvfSet[1] = 1; cyc(1); tmrOvfSet[1] = 0;
    chk("R7 timer1 set", flagsOut[3], 1'b1);
    wrReg(2'd0, 8'h88);
    chk("R7 timer1 request", {irqReq, irqIdx}, {1'b1, 3'd3});
    ack(3'd3);
    chk("R7 timer1 cleared", flagsOut[3], 1'b0);

    // serial and timer2 flags stay
    serRxSet = 1; cyc(1); serRxSet = 0;
    wrReg(2'd0, 8'h90);
    chk("R9 serial request", {irqReq, irqIdx}, {1'b1, 3'd4});
    ack(3'd4);
    chk("R9 receive flag kept", flagsOut[4], 1'b1);
    t2ExtSet = 1; cyc(1); t2ExtSet = 0;
    wrReg(2'd0, 8'hA0);
    chk("R9 timer2 request", {irqReq, irqIdx}, {1'b1, 3'd5});
    ack(3'd5);
    chk("R9 timer2 flag kept", flagsOut[7], 1'b1);

    // set beats write in the same cycle
    regWrEn = 1; regSel = 2'd2; regWrData = 8'h00; tmrOvfSet[0] = 1;
    cyc(1);
    regWrEn = 0; tmrOvfSet[0] = 0;
    chk("R10 set wins over write", flagsOut, 8'h02);

    // level mode
    wrReg(2'd2, 8'h00);
    wrReg(2'd1, 8'h00);
    extPinN[1] = 0;
    cyc(2); chk("R6 level after 2", flagsOut[2], 1'b0);
    cyc(1); chk("R6 level after 3", flagsOut[2], 1'b1);
    wrReg(2'd0, 8'h84);
    chk("R6 level request", {irqReq, irqIdx}, {1'b1, 3'd2});
    ack(3'd2);
    chk("R6 ack keeps level flag", flagsOut[2], 1'b1);
    wrReg(2'd2, 8'h00);
    chk("R6 write has no effect", flagsOut[2], 1'b1);
    extPinN[1] = 1;
    cyc(3);
    chk("R6 level follows release", flagsOut[2], 1'b0);
    chk("R6 request released", irqReq, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule